// File: doc/BRIEF.md
# Vertical Link Serial Transceiver

This block is the digital half of one chip-to-chip vertical link in a stacked package. It moves 32-bit words between the system clock domain and a single serial data line. When it transmits, it forwards its own fast clock beside the data. When it receives, it rebuilds each word using only the clock that arrives from the far chip, so the two chips never need a shared clock. A mode input selects transmit, receive or idle. The applied direction is reported back so that the coil drivers and receivers can be steered.

On the transmit side, words enter through a valid/ready port. `in_ready` drops whenever the transmit buffer has no free slot, so the sender must hold `in_data` stable with `in_valid` high until the handshake. On the receive side, words leave through a valid/ready port. `out_valid` and `out_data` stay unchanged until `out_ready` is sampled high. The far sender is never throttled, so a word that completes while every receive slot is full is dropped. The serial frame is one high start bit followed by the word, most significant bit first. The sender launches one bit on each rising edge of the fast clock, and the receiver samples on the falling edge of the forwarded clock.

Top module: `vlink_serdes`

## Requirements
- R1: `mode_req` encodes 2'b01 as transmit, 2'b10 as receive, and both 2'b00 and 2'b11 as idle. `link_mode` reports the applied mode with the same codes and never shows 2'b11.
- R2: When no transfer is pending, a change of `mode_req` appears on `link_mode` at the next rising edge of `sys_clk`.
- R3: The applied mode stays transmit until every accepted word has been sent completely. It stays receive until every received word has been delivered on `out_data` and no frame is in progress. A request to leave is applied only once that holds.
- R4: `in_ready` is high only when the applied mode and the requested mode are both transmit and a buffer slot is free. A word is taken on a `sys_clk` edge where `in_valid` and `in_ready` are both high.
- R5: Each word appears on `tx_dat` as one high start bit, then the 32 data bits most significant first. Each bit is valid on a falling edge of `tx_clk`, and `tx_dat` is low between frames.
- R6: Outside transmit mode, `tx_dat` is low and `tx_clk` shows no edges.
- R7: Received words appear on `out_data` in the order they were sent. `out_valid` and `out_data` hold until the handshake completes.
- R8: Frames that arrive while the applied mode is not receive are discarded and never appear on `out_valid`.
- R9: During and after reset, `link_mode` is idle and `in_ready`, `out_valid` and `tx_dat` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| fast_clk | input | 1 | Local fast clock used to shift out bits |
| rst_n | input | 1 | Asynchronous active-low reset, all domains |
| mode_req | input | 2 | Requested direction (R1 codes) |
| link_mode | output | 2 | Applied direction |
| in_valid | input | 1 | Transmit word offered |
| in_data | input | 32 | Transmit word |
| in_ready | output | 1 | Transmit slot free and mode allows it |
| out_valid | output | 1 | Received word available |
| out_data | output | 32 | Received word |
| out_ready | input | 1 | Consumer takes the received word |
| tx_clk | output | 1 | Forwarded fast clock, gated outside transmit |
| tx_dat | output | 1 | Serial data out |
| rx_clk | input | 1 | Forwarded clock from the far chip |
| rx_dat | input | 1 | Serial data in |

## Verification
The assertions assume that `in_data` stays stable while a word is offered. They also assume that a frame, once started by the far side, completes with its clock still running, and that the consumer never needs more receive slots than exist. The stimulus keeps within these limits. It uses two instances wired back to back on unrelated fast clocks. At most three words are ever left waiting at a stalled consumer. A sender only leaves transmit through its own request, which the block defers until the frame is finished.

// File: rtl/vlink_pkg.sv
package vlink_pkg;
  typedef enum logic [1:0] {
    LM_IDLE = 2'b00,
    LM_TX   = 2'b01,
    LM_RX   = 2'b10
  } lmode_e;

  function automatic lmode_e decode_mode(input logic [1:0] m);
    case (m)
      2'b01:   return LM_TX;
      2'b10:   return LM_RX;
      default: return LM_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/vlink_sync.sv
module vlink_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/vlink_mode_ctl.sv
module vlink_mode_ctl
  import vlink_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_req,
  input  logic       tx_drained,
  input  logic       rx_pending,
  output lmode_e     cur,
  output logic       req_tx
);
  lmode_e want;
  logic   hold;

  assign want   = decode_mode(mode_req);
  assign req_tx = (want == LM_TX);
  assign hold   = ((cur == LM_TX) && !tx_drained) || ((cur == LM_RX) && rx_pending);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cur <= LM_IDLE;
    else if (want != cur && !hold)   cur <= want;
  end
endmodule

// File: rtl/vlink_tx.sv
module vlink_tx #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 4,
  parameter int SYNC_N = 2
) (
  input  logic              sys_clk,
  input  logic              fast_clk,
  input  logic              rst_n,
  input  logic              tx_on,
  input  logic              accept_ok,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              drained,
  output logic              tx_clk,
  output logic              tx_dat
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(WORD_W + 1);

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [WORD_W-1:0] slot [DEPTH];
  logic [DEPTH-1:0]  wr_tog, rd_tog, rd_tog_s, wr_tog_f, full_s;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              push, en_f, avail_f;
  logic              busy, dat_q, gate_q;
  logic [CNT_W-1:0]  left;
  logic [WORD_W-1:0] shreg;

  // system side: slot ownership by toggle pairs
  assign full_s   = wr_tog ^ rd_tog_s;
  assign in_ready = tx_on & accept_ok & ~full_s[wr_ptr];
  assign drained  = ~|full_s;
  assign push     = in_valid & in_ready;

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_tog <= '0;
      wr_ptr <= '0;
    end else if (push) begin
      wr_tog[wr_ptr] <= ~wr_tog[wr_ptr];
      wr_ptr         <= nxt(wr_ptr);
    end
  end

  always_ff @(posedge sys_clk) begin
    if (push) slot[wr_ptr] <= in_data;
  end

  vlink_sync #(.W(DEPTH), .STAGES(SYNC_N)) u_rel_sync (
    .clk(sys_clk), .rst_n(rst_n), .d(rd_tog), .q(rd_tog_s));

  vlink_sync #(.W(DEPTH + 1), .STAGES(SYNC_N)) u_req_sync (
    .clk(fast_clk), .rst_n(rst_n), .d({tx_on, wr_tog}), .q({en_f, wr_tog_f}));

  // fast side: start bit, then MSB-first shift
  assign avail_f = wr_tog_f[rd_ptr] ^ rd_tog[rd_ptr];

  always_ff @(posedge fast_clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      dat_q  <= 1'b0;
      left   <= '0;
      shreg  <= '0;
      rd_tog <= '0;
      rd_ptr <= '0;
    end else if (!busy) begin
      if (avail_f && en_f) begin
        shreg <= slot[rd_ptr];
        busy  <= 1'b1;
        left  <= CNT_W'(WORD_W);
        dat_q <= 1'b1;
      end else begin
        dat_q <= 1'b0;
      end
    end else if (left != '0) begin
      dat_q <= shreg[WORD_W-1];
      shreg <= {shreg[WORD_W-2:0], 1'b0};
      left  <= left - 1'b1;
    end else begin
      busy           <= 1'b0;
      dat_q          <= 1'b0;
      rd_tog[rd_ptr] <= ~rd_tog[rd_ptr];
      rd_ptr         <= nxt(rd_ptr);
    end
  end

  // enable changes only while the fast clock is low
  always_ff @(negedge fast_clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= en_f;
  end

  assign tx_clk = fast_clk & gate_q;
  assign tx_dat = dat_q;
endmodule

// File: rtl/vlink_rx.sv
module vlink_rx #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 4,
  parameter int SYNC_N = 2
) (
  input  logic              sys_clk,
  input  logic              rx_clk,
  input  logic              rst_n,
  input  logic              rx_on,
  input  logic              rx_dat,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              pending
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(WORD_W + 1);

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [WORD_W-1:0] slot [DEPTH];
  logic [DEPTH-1:0]  wr_tog, rd_tog, rd_tog_r, wr_tog_s;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              samp, busy, busy_s, last, room, avail, pop;
  logic [CNT_W-1:0]  left;
  logic [WORD_W-1:0] shreg;

  // mid-bit capture on the falling forwarded edge
  always_ff @(negedge rx_clk or negedge rst_n) begin
    if (!rst_n) samp <= 1'b0;
    else        samp <= rx_dat;
  end

  vlink_sync #(.W(DEPTH), .STAGES(SYNC_N)) u_free_sync (
    .clk(rx_clk), .rst_n(rst_n), .d(rd_tog), .q(rd_tog_r));

  assign last = busy && (left == CNT_W'(1));
  assign room = ~(wr_tog[wr_ptr] ^ rd_tog_r[wr_ptr]);

  always_ff @(posedge rx_clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      left   <= '0;
      shreg  <= '0;
      wr_tog <= '0;
      wr_ptr <= '0;
    end else if (!busy) begin
      if (samp) begin
        busy <= 1'b1;
        left <= CNT_W'(WORD_W);
      end
    end else begin
      shreg <= {shreg[WORD_W-2:0], samp};
      left  <= left - 1'b1;
      if (last) begin
        busy <= 1'b0;
        if (room) begin
          wr_tog[wr_ptr] <= ~wr_tog[wr_ptr];
          wr_ptr         <= nxt(wr_ptr);
        end
      end
    end
  end

  always_ff @(posedge rx_clk) begin
    if (last && room) slot[wr_ptr] <= {shreg[WORD_W-2:0], samp};
  end

  vlink_sync #(.W(DEPTH + 1), .STAGES(SYNC_N)) u_fill_sync (
    .clk(sys_clk), .rst_n(rst_n), .d({busy, wr_tog}), .q({busy_s, wr_tog_s}));

  // system side: deliver in receive mode, drop otherwise
  assign avail     = wr_tog_s[rd_ptr] ^ rd_tog[rd_ptr];
  assign out_valid = avail & rx_on;
  assign out_data  = slot[rd_ptr];
  assign pop       = avail & (rx_on ? out_ready : 1'b1);
  assign pending   = avail | busy_s;

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_tog <= '0;
      rd_ptr <= '0;
    end else if (pop) begin
      rd_tog[rd_ptr] <= ~rd_tog[rd_ptr];
      rd_ptr         <= nxt(rd_ptr);
    end
  end
endmodule

// File: rtl/vlink_serdes.sv
module vlink_serdes
  import vlink_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 4,
  parameter int SYNC_N = 2
) (
  input  logic              sys_clk,
  input  logic              fast_clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_req,
  output logic [1:0]        link_mode,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  input  logic              out_ready,
  output logic              tx_clk,
  output logic              tx_dat,
  input  logic              rx_clk,
  input  logic              rx_dat
);
  lmode_e cur;
  logic   req_tx, tx_drained, rx_pending;

  vlink_mode_ctl u_mode (
    .clk(sys_clk), .rst_n(rst_n), .mode_req(mode_req),
    .tx_drained(tx_drained), .rx_pending(rx_pending),
    .cur(cur), .req_tx(req_tx));

  vlink_tx #(.WORD_W(WORD_W), .DEPTH(DEPTH), .SYNC_N(SYNC_N)) u_tx (
    .sys_clk(sys_clk), .fast_clk(fast_clk), .rst_n(rst_n),
    .tx_on(cur == LM_TX), .accept_ok(req_tx),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .drained(tx_drained), .tx_clk(tx_clk), .tx_dat(tx_dat));

  vlink_rx #(.WORD_W(WORD_W), .DEPTH(DEPTH), .SYNC_N(SYNC_N)) u_rx (
    .sys_clk(sys_clk), .rx_clk(rx_clk), .rst_n(rst_n),
    .rx_on(cur == LM_RX), .rx_dat(rx_dat),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .pending(rx_pending));

  assign link_mode = cur;
endmodule

// File: rtl/vlink_serdes_sva.sv
module vlink_serdes_sva
  import vlink_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_req,
  input logic [1:0]        link_mode,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              tx_drained,
  input logic              rx_pending
);
  logic [1:0] want;
  logic       busy_dir;

  assign want = (mode_req == 2'b11) ? 2'b00 : mode_req;
  assign busy_dir = (link_mode == 2'b01 && !tx_drained) || (link_mode == 2'b10 && rx_pending);

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    link_mode != 2'b11); // R1
  AST_SWITCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (want != link_mode && !busy_dir) |=> link_mode == $past(want)); // R2
  AST_TX_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    (link_mode == 2'b01 && !tx_drained) |=> link_mode == 2'b01); // R3
  AST_READY_TX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (link_mode == 2'b01 && mode_req == 2'b01)); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7
  AST_OUT_RX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> link_mode == 2'b10); // R8
endmodule

bind vlink_serdes vlink_serdes_sva #(.WORD_W(WORD_W)) u_sva (
  .clk(sys_clk), .rst_n(rst_n), .mode_req(mode_req), .link_mode(link_mode),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .tx_drained(tx_drained), .rx_pending(rx_pending));

// File: tb/vlink_serdes_test.sv
module vlink_serdes_test;
  localparam int SYS_T = 400;

  logic sys_clk = 1'b0, u_fast = 1'b0, p_fast = 1'b0, rst_n = 1'b0;
  logic [1:0]  u_mode = 2'b00, p_mode = 2'b00, u_link, p_link;
  logic        u_in_valid = 1'b0, p_in_valid = 1'b0;
  logic [31:0] u_in_data = '0, p_in_data = '0, u_out_data, p_out_data;
  logic        u_in_ready, p_in_ready, u_out_valid, p_out_valid;
  logic        u_out_ready = 1'b1, p_out_ready = 1'b1;
  logic        u_tx_clk, u_tx_dat, p_tx_clk, p_tx_dat;

  int n_chk = 0, n_fail = 0, u_edges = 0;
  logic [31:0] q_up[$], q_dn[$], q_sn[$];
  logic [31:0] e;
  logic        u_hold = 1'b0, p_hold = 1'b0;
  logic [31:0] u_hold_d, p_hold_d;
  logic        sn_busy = 1'b0;
  int          sn_left = 0;
  logic [31:0] sn_word = '0;

  always #(SYS_T/2) sys_clk = ~sys_clk;
  always #5 u_fast = ~u_fast;
  always begin #5 p_fast = 1'b1; #6 p_fast = 1'b0; end

  vlink_serdes uut (
    .sys_clk(sys_clk), .fast_clk(u_fast), .rst_n(rst_n), .mode_req(u_mode), .link_mode(u_link),
    .in_valid(u_in_valid), .in_data(u_in_data), .in_ready(u_in_ready),
    .out_valid(u_out_valid), .out_data(u_out_data), .out_ready(u_out_ready),
    .tx_clk(u_tx_clk), .tx_dat(u_tx_dat), .rx_clk(p_tx_clk), .rx_dat(p_tx_dat));

  vlink_serdes peer (
    .sys_clk(sys_clk), .fast_clk(p_fast), .rst_n(rst_n), .mode_req(p_mode), .link_mode(p_link),
    .in_valid(p_in_valid), .in_data(p_in_data), .in_ready(p_in_ready),
    .out_valid(p_out_valid), .out_data(p_out_data), .out_ready(p_out_ready),
    .tx_clk(p_tx_clk), .tx_dat(p_tx_dat), .rx_clk(u_tx_clk), .rx_dat(u_tx_dat));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge sys_clk);
    #1;
  endtask

  task automatic push_u(input logic [31:0] w);
    u_in_valid = 1'b1; u_in_data = w;
    @(negedge sys_clk);
    while (!u_in_ready) @(negedge sys_clk);
    q_up.push_back(w); q_sn.push_back(w);
    @(posedge sys_clk); #1;
    u_in_valid = 1'b0;
  endtask

  task automatic push_p(input logic [31:0] w, input bit expect_rx);
    p_in_valid = 1'b1; p_in_data = w;
    @(negedge sys_clk);
    while (!p_in_ready) @(negedge sys_clk);
    if (expect_rx) q_dn.push_back(w);
    @(posedge sys_clk); #1;
    p_in_valid = 1'b0;
  endtask

  // reference model comparison every system cycle
  always begin
    @(negedge sys_clk);
    #(SYS_T/4);
    if (rst_n) begin
      if (p_hold) check(p_out_valid && p_out_data == p_hold_d, "R7", "peer word not held", p_out_data, p_hold_d);
      if (u_hold) check(u_out_valid && u_out_data == u_hold_d, "R7", "uut word not held", u_out_data, u_hold_d);
      if (p_out_valid && p_out_ready) begin
        if (q_up.size() == 0) check(1'b0, "R7", "unexpected word at peer", p_out_data, 32'h0);
        else begin e = q_up.pop_front(); check(p_out_data == e, "R7", "peer order", p_out_data, e); end
      end
      if (u_out_valid && u_out_ready) begin
        if (q_dn.size() == 0) check(1'b0, "R8", "unexpected word at uut", u_out_data, 32'h0);
        else begin e = q_dn.pop_front(); check(u_out_data == e, "R7", "uut order", u_out_data, e); end
      end
      if (u_link != 2'b01) check(u_tx_dat == 1'b0, "R6", "tx_dat outside transmit", {31'h0, u_tx_dat}, 32'h0);
      p_hold = p_out_valid && !p_out_ready; p_hold_d = p_out_data;
      u_hold = u_out_valid && !u_out_ready; u_hold_d = u_out_data;
    end
  end

  // line sniffer: start bit then MSB-first word, sampled on falling tx_clk
  always @(negedge u_tx_clk) begin
    if (!sn_busy) begin
      if (u_tx_dat) begin sn_busy = 1'b1; sn_left = 32; end
    end else begin
      sn_word = {sn_word[30:0], u_tx_dat};
      sn_left--;
      if (sn_left == 0) begin
        sn_busy = 1'b0;
        if (q_sn.size() == 0) check(1'b0, "R5", "unexpected frame", sn_word, 32'h0);
        else begin e = q_sn.pop_front(); check(sn_word == e, "R5", "frame content", sn_word, e); end
      end
    end
  end

  always @(posedge u_tx_clk) u_edges++;

  initial begin
    repeat (20000) @(posedge sys_clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int ed0;
    cycles(3);
    rst_n = 1'b1;
    @(negedge sys_clk);
    check(u_link == 2'b00, "R9", "reset mode", {30'h0, u_link}, 32'h0);
    check(!u_in_ready && !u_out_valid && !u_tx_dat, "R9", "reset outputs",
          {29'h0, u_in_ready, u_out_valid, u_tx_dat}, 32'h0);
    u_in_valid = 1'b1;
    #1 check(!u_in_ready, "R4", "ready while idle", {31'h0, u_in_ready}, 32'h0);
    u_in_valid = 1'b0;

    cycles(1);
    u_mode = 2'b01; p_mode = 2'b10;
    cycles(1);
    check(u_link == 2'b01, "R2", "uut to transmit", {30'h0, u_link}, 32'h1);
    check(p_link == 2'b10, "R2", "peer to receive", {30'h0, p_link}, 32'h2);

    push_u(32'h8000_0001);
    for (int i = 0; i < 10; i++) push_u(32'hA5C3_0F00 ^ (i * 32'h0101_1357));
    for (int k = 0; k < 80 && q_up.size() != 0; k++) cycles(1);
    check(q_up.size() == 0, "R7", "burst delivered", q_up.size(), 32'h0);

    p_out_ready = 1'b0;
    push_u(32'h1234_5678); push_u(32'hFFFF_0000); push_u(32'h0000_0001);
    cycles(10);
    check(p_out_valid, "R7", "stalled word visible", {31'h0, p_out_valid}, 32'h1);
    p_mode = 2'b00;
    cycles(2);
    check(p_link == 2'b10, "R3", "receive held while words wait", {30'h0, p_link}, 32'h2);
    p_out_ready = 1'b1;
    cycles(10);
    check(q_up.size() == 0, "R7", "stalled words drained", q_up.size(), 32'h0);
    check(p_link == 2'b00, "R3", "receive left after drain", {30'h0, p_link}, 32'h0);

    p_mode = 2'b10;
    cycles(1);
    push_u(32'hDEAD_BEEF);
    u_mode = 2'b00;
    cycles(1);
    check(u_link == 2'b01, "R3", "transmit held mid-word", {30'h0, u_link}, 32'h1);
    for (int k = 0; k < 20 && u_link != 2'b00; k++) cycles(1);
    check(u_link == 2'b00, "R3", "transmit left", {30'h0, u_link}, 32'h0);
    check(q_sn.size() == 0, "R3", "frame finished before switch", q_sn.size(), 32'h0);
    cycles(5);
    check(q_up.size() == 0, "R7", "deferred word delivered", q_up.size(), 32'h0);

    ed0 = u_edges;
    cycles(6);
    check(u_edges == ed0, "R6", "clock quiet in idle", u_edges - ed0, 32'h0);

    p_mode = 2'b01;
    cycles(2);
    push_p(32'hBAD0_0001, 1'b0); push_p(32'hBAD0_0002, 1'b0);
    cycles(10);
    check(!u_out_valid && q_dn.size() == 0, "R8", "idle frames dropped", {31'h0, u_out_valid}, 32'h0);
    u_mode = 2'b10;
    cycles(2);
    ed0 = u_edges;
    push_p(32'h0F0F_F0F0, 1'b1); push_p(32'h7777_8888, 1'b1); push_p(32'h0000_0000, 1'b1);
    for (int k = 0; k < 40 && q_dn.size() != 0; k++) cycles(1);
    check(q_dn.size() == 0, "R8", "receive words delivered", q_dn.size(), 32'h0);
    check(u_edges == ed0, "R6", "clock quiet in receive", u_edges - ed0, 32'h0);

    p_mode = 2'b00;
    cycles(2);
    u_mode = 2'b11;
    cycles(1);
    check(u_link == 2'b00, "R1", "code 11 is idle", {30'h0, u_link}, 32'h0);

    p_mode = 2'b10; u_mode = 2'b01;
    cycles(1);
    check(u_in_ready, "R4", "ready in transmit", {31'h0, u_in_ready}, 32'h1);
    u_mode = 2'b00;
    @(negedge sys_clk);
    check(!u_in_ready && u_link == 2'b01, "R4", "ready drops on leave request",
          {30'h0, u_in_ready, u_link[0]}, 32'h1);
    cycles(5);
    summary();
  end
endmodule